// File: doc/BRIEF.md
# Static-Memory Bus Cycle Sequencer

This block turns single host requests into read and write cycles on an external asynchronous static-memory bus that is split into numbered chip-select areas. A request names the area, the direction, the address and the write data. The block drives one active-low chip enable per area, active-low read and write strobes, the address, the write data with its output enable, and it returns the captured read data with a one-cycle valid pulse.

Timing comes from an 8-bit control register, which software reads back through a 32-bit single-cycle port. The fields set the bus-clock ratio for ordinary areas, a separate ratio for one special area, an optional one bus-clock chip-enable lead for two designated areas, and a turnaround gap of 0 to 7 bus clocks after reads of the special area. The host holds a request until `busy_o` is low. The block takes its timing snapshot from the register at the moment it accepts a request.

Top module: `sram_seq`

## Requirements
- R1: After reset the control register reads 0x00000081.
- R2: Writes store only bits 7:4 and 2:0. Bits 31:8 and bit 3 always read 0.
- R3: For every area except area 9, bit 0 sets the bus clock: 1 gives two core cycles per bus clock and 0 gives one.
- R4: Area 9 takes its bus clock from bit 7 instead, with the same encoding, and bit 0 has no effect on it.
- R5: Area 4 (bit 1) and area 11 (bit 2) start with a setup phase of one bus clock when their bit is 0. In that phase the chip enable is low and both strobes are high. When the bit is 1 the strobe falls together with the chip enable. All other areas never have a setup phase.
- R6: Each access drives low only the chip enable of the requested area, with the request address on `addr_o`. It holds one bus clock of strobe and then one bus clock of release, in which the chip enable stays low and both strobes are high.
- R7: A read samples `din_i` in the last core cycle of the strobe. The sampled value appears on `rdata_o` with `rdata_valid_o` high for one cycle, in the first release cycle.
- R8: `dout_en_o` is high only during the setup and strobe phases of writes, and `dout_o` then carries the request data.
- R9: After a read of area 9, bits 6:4 set how many area-9 bus clocks the block waits with all chip enables high before it can start another access. Writes and other areas get no gap.
- R10: `busy_o` is high from the cycle after acceptance until the access and any gap end. A request is accepted only while `busy_o` is low, so a request held during busy waits and is not lost.
- R11: A register write made during an access changes only the accesses that are accepted after it.
- R12: `bclk_o` always follows the core clock undivided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Control register write data |
| reg_rdata_o | output | 32 | Control register read data |
| req_valid_i | input | 1 | Request present, held until accepted |
| req_area_i | input | AREA_W | Requested chip-select area |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Access or turnaround gap in progress |
| bclk_o | output | 1 | Bus clock pin, undivided core clock |
| ce_no | output | 2**AREA_W | Chip enables, active low, one per area |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| addr_o | output | ADDR_W | Memory address |
| dout_o | output | DATA_W | Write data to memory |
| dout_en_o | output | 1 | Data output enable |
| din_i | input | DATA_W | Read data from memory |
| rdata_o | output | DATA_W | Captured read data |
| rdata_valid_o | output | 1 | One-cycle pulse when rdata_o is new |

## Verification
The model takes a request on the first rising edge at which the request is valid and the block is idle. From the next cycle it queues one expected pin state for each core cycle: setup, strobe, release and gap, each phase being D core cycles long, where D is the ratio chosen for the area. Register read data is due in the cycle after a write. The read-data pulse is due in the first release cycle and carries the input value the bench drove in the last strobe cycle. All outputs are sampled at the falling edge and compared with the head of that queue on every cycle, so a phase that is one cycle too long or too short shows up at once.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  localparam int HOLD_W = 3;
  localparam int CFG_W  = 8;
  localparam logic [CFG_W-1:0] CFG_RST  = 8'h81;
  localparam logic [CFG_W-1:0] CFG_MASK = 8'hF7;
  localparam int B_DIV     = 0;
  localparam int B_SU_A    = 1;
  localparam int B_SU_B    = 2;
  localparam int B_HOLD    = 4;
  localparam int B_DIV_SPC = 7;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_RELEASE, PH_GAP
  } phase_e;

  typedef struct packed {
    logic              div2;
    logic              setup;
    logic [HOLD_W-1:0] hold;
  } acc_cfg_t;
endpackage

// File: rtl/sram_seq_cfg.sv
module sram_seq_cfg
  import sram_seq_pkg::*;
#(
  parameter int AREA_W    = 4,
  parameter int SPC_AREA  = 9,
  parameter int SU_AREA_A = 4,
  parameter int SU_AREA_B = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [AREA_W-1:0] area_i,
  output acc_cfg_t          cfg_o
);
  logic [CFG_W-1:0] reg_q;
  logic             unused_wdata;
  logic             is_spc;

  assign unused_wdata = ^wdata_i[31:CFG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= CFG_RST;
    else if (we_i) reg_q <= wdata_i[CFG_W-1:0] & CFG_MASK;
  end

  assign rdata_o = {{(32-CFG_W){1'b0}}, reg_q};

  assign is_spc = (area_i == AREA_W'(SPC_AREA));

  always_comb begin
    cfg_o.div2  = is_spc ? reg_q[B_DIV_SPC] : reg_q[B_DIV];
    cfg_o.setup = ((area_i == AREA_W'(SU_AREA_A)) && !reg_q[B_SU_A]) ||
                  ((area_i == AREA_W'(SU_AREA_B)) && !reg_q[B_SU_B]);
    cfg_o.hold  = is_spc ? reg_q[B_HOLD +: HOLD_W] : '0;
  end
endmodule

// File: rtl/sram_seq_tick.sv
module sram_seq_tick #(
  parameter int MAX_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic div2_i,
  output logic tick_o
);
  localparam int CNT_W = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = div2_i ? CNT_W'(1) : '0;
  assign tick_o = (cnt_q == lim);

  // divider phase restarts with each accepted access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int AREA_W = 4,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [AREA_W-1:0] req_area_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  acc_cfg_t          cfg_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              accept_o,
  output logic              div2_o,
  output phase_e            phase_o,
  output logic [AREA_W-1:0] area_o,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o
);
  phase_e            phase_q;
  acc_cfg_t          snap_q;
  logic [HOLD_W-1:0] gap_q;

  assign accept_o = req_valid_i && (phase_q == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q       <= PH_IDLE;
      snap_q        <= '0;
      gap_q         <= '0;
      area_o        <= '0;
      write_o       <= 1'b0;
      addr_o        <= '0;
      dout_o        <= '0;
      rdata_o       <= '0;
      rdata_valid_o <= 1'b0;
    end else begin
      rdata_valid_o <= 1'b0;
      if (accept_o) begin
        phase_q <= cfg_i.setup ? PH_SETUP : PH_STROBE;
        snap_q  <= cfg_i;
        area_o  <= req_area_i;
        write_o <= req_write_i;
        addr_o  <= req_addr_i;
        dout_o  <= req_wdata_i;
      end else if (tick_i) begin
        unique case (phase_q)
          PH_SETUP:  phase_q <= PH_STROBE;
          PH_STROBE: begin
            phase_q <= PH_RELEASE;
            if (!write_o) begin
              rdata_o       <= din_i;
              rdata_valid_o <= 1'b1;
            end
          end
          PH_RELEASE: begin
            if (!write_o && (snap_q.hold != '0)) begin
              phase_q <= PH_GAP;
              gap_q   <= snap_q.hold;
            end else begin
              phase_q <= PH_IDLE;
            end
          end
          PH_GAP: begin
            if (gap_q == HOLD_W'(1)) phase_q <= PH_IDLE;
            gap_q <= gap_q - HOLD_W'(1);
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign div2_o  = snap_q.div2;
  assign phase_o = phase_q;
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int AREA_W    = 4,
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int SPC_AREA  = 9,
  parameter int SU_AREA_A = 4,
  parameter int SU_AREA_B = 11
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [31:0]              reg_wdata_i,
  output logic [31:0]              reg_rdata_o,
  input  logic                     req_valid_i,
  input  logic [AREA_W-1:0]        req_area_i,
  input  logic                     req_write_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     busy_o,
  output logic                     bclk_o,
  output logic [(1<<AREA_W)-1:0]   ce_no,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [DATA_W-1:0]        dout_o,
  output logic                     dout_en_o,
  input  logic [DATA_W-1:0]        din_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rdata_valid_o
);
  localparam int NUM_AREA = 1 << AREA_W;

  acc_cfg_t          cfg;
  logic              accept;
  logic              div2;
  logic              tick;
  phase_e            phase;
  logic [AREA_W-1:0] area_q;
  logic              write_q;
  logic              ce_act;
  logic              strobe;

  sram_seq_cfg #(
    .AREA_W(AREA_W), .SPC_AREA(SPC_AREA),
    .SU_AREA_A(SU_AREA_A), .SU_AREA_B(SU_AREA_B)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .area_i(req_area_i), .cfg_o(cfg)
  );

  sram_seq_tick #(.MAX_DIV(2)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(accept), .div2_i(div2),
    .tick_o(tick)
  );

  sram_seq_fsm #(.AREA_W(AREA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_area_i(req_area_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .cfg_i(cfg),
    .tick_i(tick), .din_i(din_i), .accept_o(accept), .div2_o(div2),
    .phase_o(phase), .area_o(area_q), .write_o(write_q), .addr_o(addr_o),
    .dout_o(dout_o), .rdata_o(rdata_o), .rdata_valid_o(rdata_valid_o)
  );

  assign busy_o    = (phase != PH_IDLE);
  assign ce_act    = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                     (phase == PH_RELEASE);
  assign strobe    = (phase == PH_STROBE);
  assign rd_no     = !(strobe && !write_q);
  assign wr_no     = !(strobe && write_q);
  assign dout_en_o = write_q && ((phase == PH_SETUP) || strobe);
  assign bclk_o    = clk_i;

  for (genvar a = 0; a < NUM_AREA; a++) begin : g_ce
    assign ce_no[a] = !(ce_act && (area_q == AREA_W'(a)));
  end
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int AREA_W = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [31:0]            reg_rdata_o,
  input logic                   busy_o,
  input logic [(1<<AREA_W)-1:0] ce_no,
  input logic                   rd_no,
  input logic                   wr_no,
  input logic                   dout_en_o,
  input logic                   rdata_valid_o
);
  p_ce_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ce_no));

  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  p_strobe_in_ce_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> (ce_no != '1));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ((ce_no == '1) && rd_no && wr_no && !dout_en_o));

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[31:8] == '0) && !reg_rdata_o[3]);

  p_dout_write_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> rd_no);

  p_rvalid_after_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> $past(!rd_no));

  p_rvalid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |=> !rdata_valid_o);
endmodule

bind sram_seq sram_seq_chk #(.AREA_W(AREA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_rdata_o(reg_rdata_o), .busy_o(busy_o),
  .ce_no(ce_no), .rd_no(rd_no), .wr_no(wr_no), .dout_en_o(dout_en_o),
  .rdata_valid_o(rdata_valid_o)
);

// File: tb/sram_seq_tb_top.sv
`timescale 1ns/100ps
module sram_seq_tb_top;
  localparam int AREA_W = 4;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int NA     = 1 << AREA_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic              req_valid_i = 1'b0;
  logic [AREA_W-1:0] req_area_i = '0;
  logic              req_write_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic              busy_o, bclk_o, rd_no, wr_no, dout_en_o, rdata_valid_o;
  logic [NA-1:0]     ce_no;
  logic [ADDR_W-1:0] addr_o;
  logic [DATA_W-1:0] dout_o, rdata_o;
  logic [DATA_W-1:0] din_i = '0;

  always #2.5 clk_i = ~clk_i;

  sram_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .req_valid_i(req_valid_i), .req_area_i(req_area_i),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .busy_o(busy_o), .bclk_o(bclk_o),
    .ce_no(ce_no), .rd_no(rd_no), .wr_no(wr_no), .addr_o(addr_o),
    .dout_o(dout_o), .dout_en_o(dout_en_o), .din_i(din_i),
    .rdata_o(rdata_o), .rdata_valid_o(rdata_valid_o)
  );

  typedef struct {
    logic [NA-1:0]     ce_n;
    logic              rd_n, wr_n, den, rv;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] dout, rdata;
  } exp_t;

  exp_t  q[$];
  logic [31:0] mreg = 32'h81;
  int    cyc = 0, total = 0, bad = 0, acc_cnt = 0;
  bit    idle_now = 1'b1, done = 1'b0;
  string ctx = "R1";

  function automatic logic [DATA_W-1:0] pat(int c);
    return DATA_W'(c * 947) ^ 16'h5A5A;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (ctx %s) cyc=%0d act=%h exp=%h", tag, ctx, cyc, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // expected per-cycle pin states for one accepted access
  task automatic push_access(int area, bit wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] wd);
    int d, s, h, c0;
    exp_t e;
    d  = ((area == 9) ? mreg[7] : mreg[0]) ? 2 : 1;
    s  = (((area == 4) && !mreg[1]) || ((area == 11) && !mreg[2])) ? d : 0;
    h  = ((area == 9) && !wr) ? int'(mreg[6:4]) : 0;
    c0 = cyc;
    e.ce_n = ~(NA'(1) << area); e.addr = a; e.dout = wd; e.rdata = '0; e.rv = 1'b0;
    for (int i = 0; i < s; i++) begin
      e.rd_n = 1'b1; e.wr_n = 1'b1; e.den = wr; q.push_back(e);
    end
    for (int i = 0; i < d; i++) begin
      e.rd_n = wr; e.wr_n = !wr; e.den = wr; q.push_back(e);
    end
    for (int i = 0; i < d; i++) begin
      e.rd_n = 1'b1; e.wr_n = 1'b1; e.den = 1'b0;
      e.rv = (i == 0) && !wr;
      e.rdata = pat(c0 + s + d - 1);
      q.push_back(e);
    end
    e.rv = 1'b0; e.ce_n = '1;
    for (int i = 0; i < h * d; i++) q.push_back(e);
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      mreg = 32'h81;
      q.delete();
    end else begin
      if (idle_now && req_valid_i) begin
        push_access(int'(req_area_i), req_write_i, req_addr_i, req_wdata_i);
        acc_cnt++;
      end
      if (reg_we_i) mreg = reg_wdata_i & 32'h0000_00F7;
    end
  end

  always @(negedge clk_i) begin
    exp_t e;
    bit has;
    has = (q.size() != 0);
    if (has) e = q.pop_front();
    else begin
      e.ce_n = '1; e.rd_n = 1'b1; e.wr_n = 1'b1; e.den = 1'b0; e.rv = 1'b0;
      e.addr = '0; e.dout = '0; e.rdata = '0;
    end
    idle_now = !has;
    chk("R10 busy", 32'(busy_o), 32'(has));
    chk("R6 ce", 32'(ce_no), 32'(e.ce_n));
    chk("R5 strobes", {30'd0, rd_no, wr_no}, {30'd0, e.rd_n, e.wr_n});
    chk("R8 dout_en", 32'(dout_en_o), 32'(e.den));
    if (e.den) chk("R8 dout", 32'(dout_o), 32'(e.dout));
    if (e.ce_n != '1) chk("R6 addr", 32'(addr_o), 32'(e.addr));
    chk("R7 rvalid", 32'(rdata_valid_o), 32'(e.rv));
    if (e.rv) chk("R7 rdata", 32'(rdata_o), 32'(e.rdata));
    chk("R2 reg", reg_rdata_o, mreg);
    chk("R12 bclk low", 32'(bclk_o), 32'd0);
    din_i = pat(cyc);
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R10 watchdog act=running exp=finished");
      report();
    end
  end

  always @(posedge clk_i) begin
    #1 if (rst_ni) chk("R12 bclk high", 32'(bclk_o), 32'd1);
  end

  task automatic reg_wr(logic [31:0] v);
    @(negedge clk_i); #1;
    reg_we_i = 1'b1; reg_wdata_i = v;
    @(negedge clk_i); #1;
    reg_we_i = 1'b0;
    chk("R2 readback", reg_rdata_o, v & 32'h0000_00F7);
  endtask

  task automatic access(int area, bit wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] wd);
    int start;
    @(negedge clk_i); #1;
    start = acc_cnt;
    req_valid_i = 1'b1; req_area_i = AREA_W'(area); req_write_i = wr;
    req_addr_i = a; req_wdata_i = wd;
    do @(negedge clk_i); while (acc_cnt == start);
    #1 req_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (q.size() != 0 || busy_o);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1 chk("R1 reset value", reg_rdata_o, 32'h0000_0081);
    rst_ni = 1'b1;
    // defaults: normal areas divide by 2, special area divide by 2, setups on
    ctx = "R3";
    access(0, 0, 20'h01234, '0);
    access(4, 1, 20'h0ABCD, 16'hBEEF);
    access(11, 0, 20'h00F00, '0);
    access(9, 0, 20'h90009, '0);
    wait_idle();
    ctx = "R2";
    reg_wr(32'hFFFF_FFFF);
    reg_wr(32'hFFFF_FF08);
    ctx = "R5";
    reg_wr(32'h0000_0000);
    access(4, 0, 20'h00444, '0);
    access(11, 1, 20'h0B0B0, 16'h1234);
    access(2, 0, 20'h00222, '0);
    access(9, 1, 20'h00999, 16'h9999);
    wait_idle();
    reg_wr(32'h0000_0006);
    access(4, 1, 20'h04040, 16'hCAFE);
    access(11, 0, 20'h01111, '0);
    wait_idle();
    ctx = "R9";
    reg_wr(32'h0000_0070);
    access(9, 0, 20'h00009, '0);
    access(9, 1, 20'h00019, 16'h5555);
    access(3, 0, 20'h00333, '0);
    wait_idle();
    ctx = "R4";
    reg_wr(32'h0000_00B1);
    access(9, 0, 20'h19999, '0);
    access(5, 1, 20'h05555, 16'hA5A5);
    wait_idle();
    reg_wr(32'h0000_0001);
    access(9, 0, 20'h29999, '0);
    access(5, 0, 20'h15555, '0);
    wait_idle();
    reg_wr(32'h0000_0080);
    access(9, 1, 20'h39999, 16'h0F0F);
    access(6, 0, 20'h06666, '0);
    wait_idle();
    ctx = "R11";
    reg_wr(32'h0000_00D1);
    access(9, 0, 20'h4AAAA, '0);
    reg_wr(32'h0000_0000);
    access(9, 0, 20'h5BBBB, '0);
    access(4, 1, 20'h6CCCC, 16'h7777);
    wait_idle();
    ctx = "R10";
    access(7, 0, 20'h07777, '0);
    access(7, 1, 20'h07778, 16'h1111);
    access(8, 0, 20'h08888, '0);
    wait_idle();
    report();
  end
endmodule